// File: doc/BRIEF.md
# Prescaled Autoload Watchdog Timer

This block is a supervision timer. A fixed divide-by-12 stage feeds a 13-bit binary chain. A 3-bit select picks one chain stage, from stage 6 up to stage 13, as the tick source for an 8-bit down counter. When the counter already holds zero and a tick arrives, the block reports an overflow. It then refills the counter from an 8-bit autoload value and restarts the prescaler from zero. Because the prescaler restarts, an autoload value of zero is a usable setting.

Software keeps the timer from expiring by pulsing a feed strobe. A feed refills the counter, clears the prescaler and does not report an overflow. A mode input decides what an overflow does:

- In supervision mode, it raises a one-cycle reset request for the chip's reset network.
- In plain timer mode, it sets a sticky flag. Software clears this flag with a clear strobe.

A single-cycle overflow pulse is given in both modes.

Top module: `wdt_prescaled`

## Requirements
- R1: Synchronous active-high reset clears the prescaler, loads FFh into the counter, and drives `ovf_pulse`, `rst_req` and `ovf_flag` low. With `en` low afterwards, no overflow occurs.
- R2: With `en` held high, the first overflow occurs T = 12 × 2^(tap_sel+6) × (reload+1) rising edges after the edge that samples `feed`. `ovf_pulse` is high in the cycle that follows that edge.
- R3: A reload value of 0 is legal and gives a period of 12 × 2^(tap_sel+6) edges.
- R4: Each overflow refills the counter and clears the prescaler, so further overflows repeat every T edges with no drift.
- R5: The edge that samples `feed` produces no overflow, even when a tick that would underflow falls on the same edge. The next overflow is due T edges later.
- R6: With `wd_mode` = 1, `rst_req` is high in exactly the cycle in which `ovf_pulse` is high, and `ovf_flag` is left unchanged.
- R7: With `wd_mode` = 0, an overflow sets `ovf_flag`, which stays high, and `rst_req` stays low.
- R8: `flag_clr` clears `ovf_flag` one edge later. If an overflow sets the flag on the same edge, the set wins.
- R9: While `en` is low, nothing counts, no overflow occurs, the count is held and the prescaler is cleared. After `en` rises, the remaining ticks each take 12 × 2^(tap_sel+6) edges, counted from the first edge that samples `en` high.
- R10: `ovf_pulse` is high for exactly one cycle per overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (oscillator) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| wd_mode | input | 1 | 1: overflow requests a reset; 0: overflow sets the flag |
| tap_sel | input | 3 | Prescaler stage select, 0..7 picks stage 6..13 |
| reload | input | 8 | Autoload value for the down counter |
| feed | input | 1 | Refill counter and clear prescaler |
| flag_clr | input | 1 | Clear strobe for the sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle overflow event |
| rst_req | output | 1 | One-cycle reset request (supervision mode) |
| ovf_flag | output | 1 | Sticky overflow flag (timer mode) |

## Verification
Every result is registered once after the decision that causes it.

- After a feed, the overflow pulse, the reset request and the flag update all appear in the cycle that follows the T-th rising edge. The feed edge itself counts as edge zero.
- After an enable, the first edge that samples `en` high counts as edge one.
- A flag clear shows one edge after it is sampled.

The bench drives inputs on falling edges and samples on falling edges. It counts edges from the stimulus and compares the edge count at which the pulse first appears with the period computed from tap select and reload. It then checks the pulse, request and flag at that same sample, and again one edge later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WDT_CNT_W    = 8;
    localparam int WDT_SEL_W    = 3;
    localparam int WDT_CHAIN_W  = 13;
    localparam int WDT_TAP_BASE = 6;
    localparam int WDT_PRE_DIV  = 12;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_DEC  = 2'd1,
        ACT_FEED = 2'd2,
        ACT_AUTO = 2'd3
    } cnt_act_e;

    typedef struct packed {
        logic ovf;
        logic req;
        logic flag;
    } wdt_out_t;

    function automatic cnt_act_e pick_act(input logic feed, input logic tick, input logic zero);
        if (feed)
            return ACT_FEED;
        else if (tick && zero)
            return ACT_AUTO;
        else if (tick)
            return ACT_DEC;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/wdt_prediv.sv
module wdt_prediv #(
    parameter int DIV = wdt_pkg::WDT_PRE_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tc
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] phase;

    assign tc = run && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            phase <= '0;
        else if (run)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    // R2: the divider restarts its 12-cycle frame after every terminal count
    a_r2_div_wrap: assert property (@(posedge clk) disable iff (rst)
        tc |=> (phase == '0));

endmodule

// File: rtl/wdt_tap_chain.sv
module wdt_tap_chain #(
    parameter int CHAIN_W  = wdt_pkg::WDT_CHAIN_W,
    parameter int SEL_W    = wdt_pkg::WDT_SEL_W,
    parameter int TAP_BASE = wdt_pkg::WDT_TAP_BASE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NTAPS = 2 ** SEL_W;

    logic [CHAIN_W-1:0] chain;
    logic [NTAPS-1:0]   tap_full;

    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        assign tap_full[i] = &chain[TAP_BASE+i-1:0];
    end

    assign tick = step && tap_full[sel];

    always_ff @(posedge clk) begin
        if (rst || clr)
            chain <= '0;
        else if (step)
            chain <= chain + 1'b1;
    end

    // R4: a cleared chain never issues a tick before it has counted
    a_r4_fresh_chain: assert property (@(posedge clk) disable iff (rst)
        ($past(clr) && !$past(rst)) |-> !tick);

endmodule

// File: rtl/wdt_main_cnt.sv
module wdt_main_cnt
    import wdt_pkg::*;
#(
    parameter int CNT_W = wdt_pkg::WDT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             feed,
    input  logic [CNT_W-1:0] reload,
    output logic             underflow
);
    logic [CNT_W-1:0] count;
    cnt_act_e         act;

    always_comb begin
        act       = pick_act(feed, tick, count == '0);
        underflow = (act == ACT_AUTO);
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= '1;
        else begin
            case (act)
                ACT_FEED, ACT_AUTO: count <= reload;
                ACT_DEC:            count <= count - 1'b1;
                default:            count <= count;
            endcase
        end
    end

    // R4: an underflow leaves the counter holding the autoload value
    a_r4_reload_taken: assert property (@(posedge clk) disable iff (rst)
        ($past(underflow) && !$past(rst)) |-> (count == $past(reload)));

    // R2: a plain tick lowers the count by exactly one
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) && !$past(feed) && ($past(count) != '0) && !$past(rst))
            |-> (count == $past(count) - 1'b1));

    // R9: with no tick and no feed the count holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick) && !$past(feed) && !$past(rst)) |-> $stable(count));

endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
    import wdt_pkg::*;
#(
    parameter int CNT_W    = WDT_CNT_W,
    parameter int SEL_W    = WDT_SEL_W,
    parameter int CHAIN_W  = WDT_CHAIN_W,
    parameter int TAP_BASE = WDT_TAP_BASE,
    parameter int PRE_DIV  = WDT_PRE_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wd_mode,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic [CNT_W-1:0] reload,
    input  logic             feed,
    input  logic             flag_clr,
    output logic             ovf_pulse,
    output logic             rst_req,
    output logic             ovf_flag
);
    logic     div_tc;
    logic     tick;
    logic     uf;
    logic     pre_clr;
    wdt_out_t q;

    assign pre_clr = feed || uf || !en;

    wdt_prediv #(.DIV(PRE_DIV)) u_prediv (
        .clk (clk),
        .rst (rst),
        .run (en),
        .clr (pre_clr),
        .tc  (div_tc)
    );

    wdt_tap_chain #(
        .CHAIN_W (CHAIN_W),
        .SEL_W   (SEL_W),
        .TAP_BASE(TAP_BASE)
    ) u_chain (
        .clk  (clk),
        .rst  (rst),
        .clr  (pre_clr),
        .step (div_tc),
        .sel  (tap_sel),
        .tick (tick)
    );

    wdt_main_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .feed     (feed),
        .reload   (reload),
        .underflow(uf)
    );

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else begin
            q.ovf  <= uf;
            q.req  <= uf && wd_mode;
            q.flag <= (uf && !wd_mode) || (q.flag && !flag_clr);
        end
    end

    assign ovf_pulse = q.ovf;
    assign rst_req   = q.req;
    assign ovf_flag  = q.flag;

    // R10: the overflow event lasts a single cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> !ovf_pulse);

    // R6: a reset request only accompanies an overflow taken in supervision mode
    a_r6_req_mode: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (ovf_pulse && $past(wd_mode)));

    // R7: the flag stays set until a clear strobe is seen
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(ovf_flag) && !$past(flag_clr) && !$past(rst)) |-> ovf_flag);

    // R5: a feed edge never reports an overflow
    a_r5_feed_quiet: assert property (@(posedge clk) disable iff (rst)
        ($past(feed) && !$past(rst)) |-> !ovf_pulse);

    // R9: no overflow is taken while disabled
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |-> !ovf_pulse);

endmodule

// File: tb/wdt_prescaled_tb_top.sv
module wdt_prescaled_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic       wd_mode;
    logic [2:0] tap_sel;
    logic [7:0] reload;
    logic       feed;
    logic       flag_clr;
    logic       ovf_pulse;
    logic       rst_req;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    wdt_prescaled dut_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .wd_mode  (wd_mode),
        .tap_sel  (tap_sel),
        .reload   (reload),
        .feed     (feed),
        .flag_clr (flag_clr),
        .ovf_pulse(ovf_pulse),
        .rst_req  (rst_req),
        .ovf_flag (ovf_flag)
    );

    function automatic int period(input int sel, input int w);
        return 12 * (1 << (sel + 6)) * (w + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // call at a falling edge; returns at the falling edge after the feed edge
    task automatic feed_pulse();
        feed = 1'b1;
        @(posedge clk);
        @(negedge clk);
        feed = 1'b0;
        check(ovf_pulse == 1'b0, "R5 feed edge event", int'(ovf_pulse), 0);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // counts edges until ovf_pulse shows; start is the edge count already elapsed
    task automatic run_window(input int start, input int exp, input string req);
        int  n    = start;
        bit  seen = 0;
        while (!seen && n < exp + 200) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (ovf_pulse) seen = 1;
        end
        check(seen && n == exp, req, n, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; en = 1'b0; wd_mode = 1'b0; tap_sel = 3'd0;
        reload = 8'd0; feed = 1'b0; flag_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(ovf_pulse == 0, "R1 ovf_pulse", int'(ovf_pulse), 0);
        check(rst_req == 0, "R1 rst_req", int'(rst_req), 0);
        check(ovf_flag == 0, "R1 ovf_flag", int'(ovf_flag), 0);
        begin
            int hits = 0;
            for (int i = 0; i < 2000; i++) begin
                @(negedge clk);
                if (ovf_pulse) hits++;
            end
            check(hits == 0, "R1 idle after reset", hits, 0);
        end

        // R3 / R2 / R7 / R4 / R10: timer mode, zero reload, fastest tap
        en = 1'b1; tap_sel = 3'd0; reload = 8'd0; wd_mode = 1'b0;
        feed_pulse();
        run_window(0, period(0, 0), "R3 zero reload period");
        check(rst_req == 0, "R7 no reset request", int'(rst_req), 0);
        check(ovf_flag == 1, "R7 flag set", int'(ovf_flag), 1);
        @(posedge clk);
        @(negedge clk);
        check(ovf_pulse == 0, "R10 pulse width", int'(ovf_pulse), 0);
        check(ovf_flag == 1, "R7 flag sticky", int'(ovf_flag), 1);
        run_window(1, period(0, 0), "R4 autoload repeat period");

        // R8 clear
        clear_flag();
        check(ovf_flag == 0, "R8 flag cleared", int'(ovf_flag), 0);

        // R5 feed on the underflow edge
        feed_pulse();
        begin
            int hits = 0;
            for (int i = 0; i < period(0, 0) - 1; i++) begin
                @(negedge clk);
                if (ovf_pulse) hits++;
            end
            check(hits == 0, "R5 early event", hits, 0);
        end
        feed_pulse();
        run_window(0, period(0, 0), "R5 period after feed");

        // R8 set beats clear on the same edge
        clear_flag();
        feed_pulse();
        repeat (period(0, 0) - 1) @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
        check(ovf_pulse == 1, "R8 overflow on clear edge", int'(ovf_pulse), 1);
        check(ovf_flag == 1, "R8 set wins", int'(ovf_flag), 1);
        clear_flag();

        // R6 supervision mode, R2 wider tap
        wd_mode = 1'b1; tap_sel = 3'd2; reload = 8'd1;
        feed_pulse();
        run_window(0, period(2, 1), "R2 period tap2 w1");
        check(rst_req == 1, "R6 reset request", int'(rst_req), 1);
        check(ovf_flag == 0, "R6 flag untouched", int'(ovf_flag), 0);
        @(posedge clk);
        @(negedge clk);
        check(rst_req == 0, "R6 request width", int'(rst_req), 0);

        // R9 disable and resume
        wd_mode = 1'b0; tap_sel = 3'd0; reload = 8'd1;
        feed_pulse();
        repeat (800) @(negedge clk);
        en = 1'b0;
        begin
            int hits = 0;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                if (ovf_pulse) hits++;
            end
            check(hits == 0, "R9 quiet while disabled", hits, 0);
        end
        en = 1'b1;
        run_window(0, period(0, 0), "R9 resume remaining tick");
        clear_flag();

        // R2 / R6 / R7 random pairs
        for (int k = 0; k < 6; k++) begin
            int  s = int'($urandom % 2);
            int  w = int'($urandom % 8);
            bit  m = 1'($urandom % 2);
            tap_sel = 3'(s); reload = 8'(w); wd_mode = m;
            clear_flag();
            feed_pulse();
            run_window(0, period(s, w), "R2 random period");
            check(rst_req == m, "R6 random request", int'(rst_req), int'(m));
            check(ovf_flag == !m, "R7 random flag", int'(ovf_flag), int'(!m));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule